// File: doc/BRIEF.md
# Configurable Integer Min/Max Unit

This unit returns either the smaller or the larger of two integer operands. A three-bit mode field picks three things: whether the ordering is signed or unsigned, whether it looks at the full operand width or only at the low half, and whether the minimum or the maximum is wanted. All eight variants share one unsigned less-than comparator. Half-width mode moves each operand's low half into the upper half and fills the lower half with zeros. Signed mode inverts the top bit of both comparison values. Max mode exchanges the two comparison values before the less-than test. The value written out is always the complete, untouched source operand that was chosen, even in half-width mode.

A record flag asks the unit to also report a four-bit condition nibble. It holds less-than, greater-than or equal from comparing the first operand against the second, followed by a sticky overflow bit supplied by the caller. When the index of the first-operand register is zero, the first operand is the constant zero and not the value presented. Results are registered: they appear one clock after an input strobe, together with an output strobe.

Top module: `minmax_unit`

## Requirements
- R1: Mode bit mode[0]=1 selects maximum and mode[0]=0 selects minimum. With mode[2:1]=00 the ordering is unsigned over the full width: mode 0 gives the unsigned minimum and mode 1 the unsigned maximum.
- R2: mode[1]=1 selects two's-complement ordering. Mode 2 gives the signed minimum and mode 3 the signed maximum.
- R3: mode[2]=1 (modes 4 to 7) orders the operands by their low XLEN/2 bits only, with the same signed and max meanings as R1 and R2. The result is still the full, unmodified XLEN-bit operand that was chosen.
- R4: When ra_idx is zero, the first operand is the constant zero and ra_val has no effect on the result or on the condition nibble.
- R5: When the compared values are equal, the second operand (rb_val) is returned, for both minimum and maximum. This includes half-width ties whose upper halves differ.
- R6: With rec=1, cr_we is 1 and cr_nib = {lt, gt, eq, so_in}, bits 3 down to 0. The comparison is first operand against second after the half-width and signed adjustments, and is never swapped by max mode. Exactly one of bits 3..1 is set.
- R7: With rec=0, cr_we is 0 and cr_nib is 0.
- R8: out_valid rises in the cycle after in_valid and lasts one cycle per strobe. result changes only on a strobe and otherwise holds its value.
- R9: After reset, out_valid, cr_we, result and cr_nib are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| ra_idx | input | IDX_W | First-operand register index; zero forces the operand to zero |
| ra_val | input | XLEN | First operand value |
| rb_val | input | XLEN | Second operand value |
| mode | input | 3 | [2] half-width, [1] signed, [0] maximum |
| rec | input | 1 | Record flag: produce the condition nibble |
| so_in | input | 1 | Sticky overflow bit appended to the nibble |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | XLEN | Selected source operand |
| cr_we | output | 1 | Condition nibble write enable |
| cr_nib | output | 4 | {lt, gt, eq, so} |

## Verification
The hardest case to reach is the half-width tie where the upper halves differ. Here the correct answer is the second operand, while a full-width comparison would pick the other one, so an error in masking or tie-breaking would return a plausible value. The vector table gives pairs with equal low halves and opposite upper halves in both min and max modes. It also gives a zero-index case in which the presented first-operand value would reverse the outcome if it leaked through. It uses the most negative value against one, so the signed and unsigned answers split on the same pair of inputs.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned HALF_BIT = 2;
  localparam int unsigned SGN_BIT  = 1;
  localparam int unsigned MAX_BIT  = 0;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_nib_t;
endpackage

// File: rtl/mm_operand_prep.sv
module mm_operand_prep #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  logic            half,
  input  logic            sgn,
  output logic [XLEN-1:0] cmp_val
);
  localparam int unsigned HW = XLEN / 2;

  function automatic logic [XLEN-1:0] prep_fn(input logic [XLEN-1:0] v,
                                              input logic h, input logic s);
    logic [XLEN-1:0] t;
    t = h ? {v[HW-1:0], {HW{1'b0}}} : v;
    if (s) t[XLEN-1] = ~t[XLEN-1];
    return t;
  endfunction

  assign cmp_val = prep_fn(val, half, sgn);

  // R3: in half-width mode the lower half of the comparison value is zero
  always_comb begin
    if (!$isunknown({half, cmp_val}) && half)
      assert_half_low_zero_R3: assert (cmp_val[HW-1:0] == '0);
  end
endmodule

// File: rtl/mm_compare.sv
module mm_compare #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] ca,
  input  logic [XLEN-1:0] cb,
  output logic            lt,
  output logic            gt,
  output logic            eq
);
  assign lt = ca < cb;
  assign gt = ca > cb;
  assign eq = ca == cb;

  // R6: exactly one relation holds
  always_comb begin
    if (!$isunknown({ca, cb}))
      assert_one_relation_R6: assert ($countones({lt, gt, eq}) == 1);
  end
endmodule

// File: rtl/mm_select.sv
module mm_select #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] ca,
  input  logic [XLEN-1:0] cb,
  input  logic            want_max,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            pick_a,
  output logic [XLEN-1:0] chosen
);
  logic [XLEN-1:0] left_v, right_v;

  always_comb begin
    if (want_max) begin
      left_v  = cb;
      right_v = ca;
    end else begin
      left_v  = ca;
      right_v = cb;
    end
  end

  assign pick_a = left_v < right_v;
  assign chosen = pick_a ? opa : opb;

  // R5: equal comparison values never choose the first operand
  always_comb begin
    if (!$isunknown({ca, cb}) && ca == cb)
      assert_tie_second_R5: assert (!pick_a);
  end
endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
  import minmax_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [MODE_W-1:0] mode,
  input  logic              rec,
  input  logic              so_in,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic              cr_we,
  output logic [3:0]        cr_nib
);
  localparam int unsigned NOPS = 2;

  logic [XLEN-1:0] ra_eff;
  logic [XLEN-1:0] src_v [NOPS];
  logic [XLEN-1:0] cmp_v [NOPS];
  logic            rel_lt, rel_gt, rel_eq;
  logic            pick_a;
  logic [XLEN-1:0] chosen;
  cond_nib_t       nib_next;

  assign ra_eff   = (ra_idx == '0) ? '0 : ra_val;
  assign src_v[0] = ra_eff;
  assign src_v[1] = rb_val;

  for (genvar g = 0; g < NOPS; g++) begin : g_prep
    mm_operand_prep #(.XLEN(XLEN)) u_prep (
      .val    (src_v[g]),
      .half   (mode[HALF_BIT]),
      .sgn    (mode[SGN_BIT]),
      .cmp_val(cmp_v[g])
    );
  end

  mm_compare #(.XLEN(XLEN)) u_cmp (
    .ca(cmp_v[0]), .cb(cmp_v[1]),
    .lt(rel_lt), .gt(rel_gt), .eq(rel_eq)
  );

  mm_select #(.XLEN(XLEN)) u_sel (
    .ca      (cmp_v[0]),
    .cb      (cmp_v[1]),
    .want_max(mode[MAX_BIT]),
    .opa     (ra_eff),
    .opb     (rb_val),
    .pick_a  (pick_a),
    .chosen  (chosen)
  );

  assign nib_next = '{lt: rel_lt, gt: rel_gt, eq: rel_eq, so: so_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cr_we     <= 1'b0;
      cr_nib    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= chosen;
        cr_we  <= rec;
        cr_nib <= rec ? nib_next : 4'b0000;
      end else begin
        cr_we  <= 1'b0;
      end
    end
  end

  assert_nib_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_nib[3:1]) == 1);

  assert_nib_so_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rec |=> cr_nib[0] == $past(so_in));

  assert_no_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rec |=> !cr_we && cr_nib == 4'b0000);

  assert_result_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (result == $past(ra_eff)) || (result == $past(rb_val)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && !out_valid);

  assert_zero_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ra_idx == '0 && mode == 3'b000 |=> result == '0);
endmodule

// File: tb/minmax_unit_test.sv
`timescale 1ns/1ps
module minmax_unit_test;
  localparam int XLEN = 64;
  localparam int NV   = 16;

  typedef struct packed {
    logic [4:0]  idx;
    logic [63:0] a;
    logic [63:0] b;
    logic [2:0]  mode;
    logic        rec;
    logic        so;
    logic [63:0] res;
    logic [3:0]  nib;
    logic [3:0]  req;
  } vec_t;

  // nib = {lt, gt, eq, so}
  localparam vec_t VECS [NV] = '{
    '{5'd1, 64'h1, 64'h8000_0000_0000_0000, 3'd0, 1'b1, 1'b0, 64'h1, 4'h8, 4'd1},                    // R1 umin
    '{5'd1, 64'h1, 64'h8000_0000_0000_0000, 3'd1, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 4'h8, 4'd1},  // R1 umax
    '{5'd1, 64'h1, 64'h8000_0000_0000_0000, 3'd2, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 4'h4, 4'd2},  // R2 smin
    '{5'd1, 64'h1, 64'h8000_0000_0000_0000, 3'd3, 1'b1, 1'b0, 64'h1, 4'h4, 4'd2},                    // R2 smax
    '{5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 3'd2, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'h9, 4'd2},  // R2 -1 vs 5
    '{5'd3, 64'h0000_0001_0000_0005, 64'hFFFF_0000_0000_0003, 3'd4, 1'b1, 1'b0,
      64'hFFFF_0000_0000_0003, 4'h4, 4'd3},                                                          // R3 half umin
    '{5'd3, 64'h0000_0000_8000_0000, 64'h1234_0000_0000_0007, 3'd7, 1'b1, 1'b1,
      64'h1234_0000_0000_0007, 4'h9, 4'd3},                                                          // R3 half smax
    '{5'd3, 64'h0000_0000_8000_0000, 64'h1234_0000_0000_0007, 3'd6, 1'b1, 1'b0,
      64'h0000_0000_8000_0000, 4'h8, 4'd3},                                                          // R3 half smin
    '{5'd4, 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 3'd4, 1'b1, 1'b0,
      64'h5555_0000_0000_0042, 4'h2, 4'd5},                                                          // R5 half tie min
    '{5'd4, 64'hAAAA_0000_0000_0042, 64'h5555_0000_0000_0042, 3'd5, 1'b1, 1'b0,
      64'h5555_0000_0000_0042, 4'h2, 4'd5},                                                          // R5 half tie max
    '{5'd0, 64'h7, 64'h3, 3'd1, 1'b1, 1'b0, 64'h3, 4'h8, 4'd4},                                      // R4 zero idx max
    '{5'd0, 64'h7, 64'h3, 3'd0, 1'b1, 1'b0, 64'h0, 4'h8, 4'd4},                                      // R4 zero idx min
    '{5'd5, 64'h5, 64'h9, 3'd3, 1'b0, 1'b1, 64'h9, 4'h0, 4'd7},                                      // R7 no record
    '{5'd5, 64'h9, 64'h5, 3'd1, 1'b1, 1'b0, 64'h9, 4'h4, 4'd6},                                      // R6 max, unswapped
    '{5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 3'd3, 1'b1, 1'b0,
      64'hFFFF_FFFF_FFFF_FFFF, 4'h4, 4'd2},                                                          // R2 -1 vs -2
    '{5'd7, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 3'd2, 1'b1, 1'b1,
      64'h0123_4567_89AB_CDEF, 4'h3, 4'd6}                                                           // R6 equal
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [4:0]      ra_idx = '0;
  logic [XLEN-1:0] ra_val = '0;
  logic [XLEN-1:0] rb_val = '0;
  logic [2:0]      mode = '0;
  logic            rec = 1'b0;
  logic            so_in = 1'b0;
  logic            out_valid;
  logic [XLEN-1:0] result;
  logic            cr_we;
  logic [3:0]      cr_nib;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  minmax_unit #(.XLEN(XLEN), .IDX_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ra_idx(ra_idx),
    .ra_val(ra_val), .rb_val(rb_val), .mode(mode), .rec(rec), .so_in(so_in),
    .out_valid(out_valid), .result(result), .cr_we(cr_we), .cr_nib(cr_nib)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    ra_idx = v.idx; ra_val = v.a; rb_val = v.b;
    mode = v.mode; rec = v.rec; so_in = v.so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset cr_we", {63'd0, cr_we}, 64'd0);
    check("R9 reset cr_nib", {60'd0, cr_nib}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      run_op(VECS[i]);
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check({tag, " result"}, result, VECS[i].res);
      check({tag, " cr_nib"}, {60'd0, cr_nib}, {60'd0, VECS[i].nib});
      check({tag, " cr_we"}, {63'd0, cr_we}, {63'd0, VECS[i].rec});
      check({"R8 ", tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
    end

    // R8: inputs change without a strobe; result holds, out_valid drops
    @(negedge clk);
    ra_idx = 5'd9; ra_val = 64'hDEAD; rb_val = 64'hBEEF; mode = 3'd1; rec = 1'b1;
    @(negedge clk);
    check("R8 hold result", result, 64'h0123_4567_89AB_CDEF);
    check("R8 no strobe out_valid", {63'd0, out_valid}, 64'd0);
    check("R8 no strobe cr_we", {63'd0, cr_we}, 64'd0);

    // R7 after a recorded op: nibble cleared by a non-recorded op
    run_op('{5'd1, 64'h2, 64'h1, 3'd0, 1'b1, 1'b1, 64'h1, 4'h5, 4'd6});
    check("R6 recorded gt", {60'd0, cr_nib}, 64'h5);
    run_op('{5'd1, 64'h2, 64'h1, 3'd0, 1'b0, 1'b1, 64'h1, 4'h0, 4'd7});
    check("R7 cleared nibble", {60'd0, cr_nib}, 64'h0);
    check("R7 cleared cr_we", {63'd0, cr_we}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule